// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block is the register front end of an interrupt distributor. A single-cycle register bus carries an offset, a write flag, a size (one byte or one 32-bit word) and write data. Each access first goes through a width and alignment check. Accepted accesses are then decoded onto per-interrupt state:

- an enable bit for each interrupt;
- a priority byte for each interrupt;
- a CPU target byte for each interrupt;
- a two-bit trigger configuration for each interrupt.

Every request gets a response one cycle later. The response carries the read data and a fault flag.

Some regions are deliberately inert: they read as zero and drop writes. These are:

- the group registers;
- all pending/active set and clear registers;
- the software-interrupt pending registers;
- the configuration words of the first 32 interrupts;
- every reserved offset.

A write to the software-interrupt register does not touch local state. Instead it produces a one-cycle pulse carrying the decoded interrupt number, the target-list filter and the CPU list. Downstream logic uses that pulse to deliver the interrupt.

The number of interrupts is a parameter (a multiple of 32, at most 1024). Offsets that address interrupt numbers at or above it read as zero and have no storage behind them.

Top module: `dist_regs`

## Requirements
- R1: Byte accesses are legal only in the priority region (0x400–0x7FF), the target region (0x800–0xBFF) and the software-interrupt pending region (0xF10–0xF2F). Word accesses are legal at any offset whose low two bits are zero. Every other access returns rsp_fault=1.
- R2: A word write to the enable-set region (0x100–0x17F) sets the enable of interrupt 32×((offset−0x100)/4)+b for each 1 in bit b. The same write to the enable-clear region (0x180–0x1FF) clears those enables. Zero bits change nothing. Reading either region returns the 32 enable bits, with bit b belonging to that same interrupt.
- R3: A priority write of size N (1 or 4) at byte offset p stores data byte k into interrupt p−0x400+k. A byte write uses only data bits 7:0. A read packs the stored bytes back in the same order; a byte read returns its byte in bits 7:0 with the upper bits zero.
- R4: Target bytes of interrupts 0–31 always read 0x01 and ignore writes. Target bytes of interrupts 32 and up are writable per byte lane, with the same lane order as R3.
- R5: Configuration words (0xC00–0xCFF) hold 2 bits per interrupt, interrupt 16w+j in bits 2j+1:2j of word w. Words 0 and 1 read zero and ignore writes.
- R6: An accepted word write at 0xF00 pulses sgi_valid for exactly one cycle, in the cycle after the request. The pulse carries sgi_intid = data[3:0], sgi_cpus = data[23:16] and sgi_filter = data[25:24].
- R7: The software-interrupt register at 0xF00 is write-only and reads zero. The following regions read zero and ignore writes: group (0x080–0x0FF), pending/active set/clear (0x200–0x3FF) and software-interrupt pending (0xF10–0xF2F).
- R8: The type register (0x004) reads {NUM_CPU−1 in bits 7:5, NUM_IRQ/32−1 in bits 4:0}, which is 0xE1 by default. The implementer register (0x008) reads IMPL_ID, which is 0x01000A5C by default. The peripheral-ID2 register (0xFE8) reads 0x20. All three ignore writes. Bit 0 of the control register (0x000) is the distributor enable: it is writable, it reads back, and it drives dist_enable.
- R9: Reserved offsets read zero, ignore writes, and fault only under the width rule of R1.
- R10: Enable, priority, target and configuration positions for interrupt numbers at or above NUM_IRQ read zero and ignore writes.
- R11: A faulted access changes no state, raises no software-interrupt pulse, and returns rsp_rdata=0.
- R12: After reset, every enable, priority, configuration bit and the control bit are zero. rsp_valid follows req_valid one cycle later. rsp_rdata is zero for write responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 32-bit access, 0 = single byte |
| req_offset | input | 12 | Byte offset into the register space |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data, zero for writes and faults |
| rsp_fault | output | 1 | Access violated the width/alignment rule |
| sgi_valid | output | 1 | Software-interrupt request pulse |
| sgi_intid | output | 4 | Requested software interrupt number |
| sgi_filter | output | 2 | Target-list filter |
| sgi_cpus | output | 8 | CPU target list |
| dist_enable | output | 1 | Distributor enable from the control register |

## Verification
The per-interrupt decode is exercised with several input patterns, and each pattern separates a different class of error:

- Sparse enable masks, including bit 31 and bits in the second word, catch a wrong word or bit mapping.
- Distinct byte values in every priority and target lane catch a reversed lane order.
- Byte writes that carry junk in the upper data bits, and land at every lane offset, catch a byte write that picks the wrong data bits.
- Configuration patterns such as 0xA5A55A5A catch a swapped field within a word.

Illegal widths are then sent at mutable registers and at the software-interrupt register. Reading the state back afterwards shows whether a fault leaked into a write or a pulse. Writes to read-only, inert and out-of-range offsets are each followed by a read of the same place.

// File: rtl/dist_pkg.sv
package dist_pkg;

    typedef enum logic [3:0] {
        RG_CTRL, RG_TYPE, RG_IIDR, RG_GROUP, RG_EN_SET, RG_EN_CLR,
        RG_PEND_ACT, RG_PRIO, RG_TGT, RG_CFG, RG_SGI, RG_SGI_PEND,
        RG_PID2, RG_RSVD
    } region_e;

    typedef struct packed {
        logic        wr;
        logic        word;
        logic [11:0] off;
        logic [31:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic [3:0] intid;
        logic [1:0] filter;
        logic [7:0] cpus;
    } sgi_req_t;

    localparam logic [31:0] PID2_VALUE = 32'h0000_0020;

    function automatic region_e classify(input logic [11:0] off);
        region_e r;
        if (off < 12'h004)                        r = RG_CTRL;
        else if (off < 12'h008)                   r = RG_TYPE;
        else if (off < 12'h00C)                   r = RG_IIDR;
        else if (off < 12'h080)                   r = RG_RSVD;
        else if (off < 12'h100)                   r = RG_GROUP;
        else if (off < 12'h180)                   r = RG_EN_SET;
        else if (off < 12'h200)                   r = RG_EN_CLR;
        else if (off < 12'h400)                   r = RG_PEND_ACT;
        else if (off < 12'h800)                   r = RG_PRIO;
        else if (off < 12'hC00)                   r = RG_TGT;
        else if (off < 12'hD00)                   r = RG_CFG;
        else if (off >= 12'hF00 && off < 12'hF04) r = RG_SGI;
        else if (off >= 12'hF10 && off < 12'hF30) r = RG_SGI_PEND;
        else if (off >= 12'hFE8 && off < 12'hFEC) r = RG_PID2;
        else                                      r = RG_RSVD;
        return r;
    endfunction

    function automatic logic byte_legal(input region_e r);
        return (r == RG_PRIO) || (r == RG_TGT) || (r == RG_SGI_PEND);
    endfunction

endpackage

// File: rtl/dist_access_check.sv
module dist_access_check
    import dist_pkg::*;
(
    input  logic     req_valid,
    input  bus_req_t req,
    output region_e  region,
    output logic     fault,
    output logic     wr_ok,
    output logic     rd_ok
);
    logic legal;

    always_comb begin
        region = classify(req.off);
        if (req.word) legal = (req.off[1:0] == 2'b00);
        else          legal = byte_legal(region);
        fault = req_valid && !legal;
        wr_ok = req_valid && legal && req.wr;
        rd_ok = req_valid && legal && !req.wr;
    end
endmodule

// File: rtl/dist_irq_state.sv
module dist_irq_state
    import dist_pkg::*;
#(
    parameter int          NUM_IRQ  = 64,
    parameter logic [7:0]  PRIV_TGT = 8'h01
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_ok,
    input  region_e     region,
    input  bus_req_t    req,
    output logic [31:0] rd_data
);
    localparam int IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

    logic       en_q  [NUM_IRQ];
    logic [7:0] pr_q  [NUM_IRQ];
    logic [7:0] tg_q  [NUM_IRQ];
    logic [1:0] cf_q  [NUM_IRQ];

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
        localparam int W32 = i / 32;
        localparam int B32 = i % 32;
        localparam int W4  = i / 4;
        localparam int L4  = i % 4;
        localparam int W16 = i / 16;
        localparam int L16 = i % 16;

        logic       en_r;
        logic [7:0] pr_r;
        logic [7:0] tg_r;
        logic [1:0] cf_r;
        logic       lane_hit;

        assign lane_hit = req.word ? (req.off[9:2] == 8'(W4)) : (req.off[9:0] == 10'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                en_r <= 1'b0;
                pr_r <= 8'h00;
                tg_r <= (i < 32) ? PRIV_TGT : 8'h00;
                cf_r <= 2'b00;
            end else if (wr_ok) begin
                if (region == RG_EN_SET && req.off[6:2] == 5'(W32) && req.wdata[B32])
                    en_r <= 1'b1;
                if (region == RG_EN_CLR && req.off[6:2] == 5'(W32) && req.wdata[B32])
                    en_r <= 1'b0;
                if (region == RG_PRIO && lane_hit)
                    pr_r <= req.word ? req.wdata[8*L4 +: 8] : req.wdata[7:0];
                if (i >= 32 && region == RG_TGT && lane_hit)
                    tg_r <= req.word ? req.wdata[8*L4 +: 8] : req.wdata[7:0];
                if (i >= 32 && region == RG_CFG && req.off[7:2] == 6'(W16))
                    cf_r <= req.wdata[2*L16 +: 2];
            end
        end

        assign en_q[i] = en_r;
        assign pr_q[i] = pr_r;
        assign tg_q[i] = tg_r;
        assign cf_q[i] = cf_r;
    end

    always_comb begin
        int idx;
        rd_data = 32'h0;
        idx = 0;
        case (region)
            RG_EN_SET, RG_EN_CLR: begin
                for (int k = 0; k < 32; k++) begin
                    idx = int'(req.off[6:2]) * 32 + k;
                    if (idx < NUM_IRQ) rd_data[k] = en_q[IW'(idx)];
                end
            end
            RG_PRIO, RG_TGT: begin
                for (int k = 0; k < 4; k++) begin
                    if (req.word || k == 0) begin
                        idx = req.word ? int'({req.off[9:2], 2'b00}) + k : int'(req.off[9:0]);
                        if (idx < NUM_IRQ)
                            rd_data[8*k +: 8] = (region == RG_PRIO) ? pr_q[IW'(idx)] : tg_q[IW'(idx)];
                    end
                end
            end
            RG_CFG: begin
                for (int k = 0; k < 16; k++) begin
                    idx = int'(req.off[7:2]) * 16 + k;
                    if (idx >= 32 && idx < NUM_IRQ) rd_data[2*k +: 2] = cf_q[IW'(idx)];
                end
            end
            default: rd_data = 32'h0;
        endcase
    end
endmodule

// File: rtl/dist_regs.sv
module dist_regs
    import dist_pkg::*;
#(
    parameter int          NUM_IRQ  = 64,
    parameter int          NUM_CPU  = 8,
    parameter logic [31:0] IMPL_ID  = 32'h0100_0A5C,
    parameter logic [7:0]  PRIV_TGT = 8'h01
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic        req_word,
    input  logic [11:0] req_offset,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        rsp_fault,
    output logic        sgi_valid,
    output logic [3:0]  sgi_intid,
    output logic [1:0]  sgi_filter,
    output logic [7:0]  sgi_cpus,
    output logic        dist_enable
);
    localparam logic [31:0] TYPE_VALUE = {24'h0, 3'(NUM_CPU - 1), 5'(NUM_IRQ / 32 - 1)};

    initial begin
        if (NUM_IRQ % 32 != 0 || NUM_IRQ < 32 || NUM_IRQ > 1024)
            $error("NUM_IRQ must be a multiple of 32 in 32..1024");
        if (NUM_CPU < 1 || NUM_CPU > 8)
            $error("NUM_CPU must be in 1..8");
    end

    bus_req_t    req;
    region_e     region;
    logic        fault, wr_ok, rd_ok;
    logic [31:0] irq_rd, rd_mux;
    logic        ctrl_q;
    sgi_req_t    sgi_q, sgi_d;

    assign req = '{wr: req_write, word: req_word, off: req_offset, wdata: req_wdata};

    dist_access_check u_chk_acc (
        .req_valid (req_valid),
        .req       (req),
        .region    (region),
        .fault     (fault),
        .wr_ok     (wr_ok),
        .rd_ok     (rd_ok)
    );

    dist_irq_state #(.NUM_IRQ(NUM_IRQ), .PRIV_TGT(PRIV_TGT)) u_state (
        .clk     (clk),
        .rst     (rst),
        .wr_ok   (wr_ok),
        .region  (region),
        .req     (req),
        .rd_data (irq_rd)
    );

    always_comb begin
        case (region)
            RG_CTRL:                            rd_mux = {31'h0, ctrl_q};
            RG_TYPE:                            rd_mux = TYPE_VALUE;
            RG_IIDR:                            rd_mux = IMPL_ID;
            RG_PID2:                            rd_mux = PID2_VALUE;
            RG_EN_SET, RG_EN_CLR, RG_PRIO,
            RG_TGT, RG_CFG:                     rd_mux = irq_rd;
            default:                            rd_mux = 32'h0;
        endcase
        sgi_d = '{intid: req_wdata[3:0], filter: req_wdata[25:24], cpus: req_wdata[23:16]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= 32'h0;
            rsp_fault <= 1'b0;
            sgi_valid <= 1'b0;
            sgi_q     <= '0;
            ctrl_q    <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_fault <= fault;
            rsp_rdata <= rd_ok ? rd_mux : 32'h0;
            sgi_valid <= wr_ok && region == RG_SGI;
            if (wr_ok && region == RG_SGI) sgi_q <= sgi_d;
            if (wr_ok && region == RG_CTRL) ctrl_q <= req_wdata[0];
        end
    end

    assign sgi_intid   = sgi_q.intid;
    assign sgi_filter  = sgi_q.filter;
    assign sgi_cpus    = sgi_q.cpus;
    assign dist_enable = ctrl_q;
endmodule

// File: rtl/dist_regs_checker.sv
module dist_regs_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_write,
    input logic        req_word,
    input logic [11:0] req_offset,
    input logic        rsp_valid,
    input logic        rsp_fault,
    input logic [31:0] rsp_rdata,
    input logic        sgi_valid,
    input logic        dist_enable
);
    AST_RSP_TRACKS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);                                                // R12
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);                                              // R12
    AST_FAULT_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_rdata == 32'h0));                      // R11
    AST_LOW_BYTE_FAULTS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_word && req_offset < 12'h400) |=> rsp_fault);         // R1
    AST_SGI_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        sgi_valid |-> $past(req_valid && req_write && req_word && req_offset == 12'hF00)); // R6
    AST_CTRL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_write && req_offset[11:2] == 10'h0) |=> $stable(dist_enable)); // R8
endmodule

bind dist_regs dist_regs_checker u_props (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_word    (req_word),
    .req_offset  (req_offset),
    .rsp_valid   (rsp_valid),
    .rsp_fault   (rsp_fault),
    .rsp_rdata   (rsp_rdata),
    .sgi_valid   (sgi_valid),
    .dist_enable (dist_enable)
);

// File: tb/sim_dist_regs.sv
module sim_dist_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
    logic [11:0] req_offset = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_fault, sgi_valid, dist_enable;
    logic [31:0] rsp_rdata;
    logic [3:0]  sgi_intid;
    logic [1:0]  sgi_filter;
    logic [7:0]  sgi_cpus;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [31:0] exp_d_q [$];
    logic        exp_f_q [$];
    string       exp_t_q [$];
    logic [13:0] exp_s_q [$];

    always #5 clk = ~clk;

    dist_regs u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_word(req_word), .req_offset(req_offset), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault),
        .sgi_valid(sgi_valid), .sgi_intid(sgi_intid), .sgi_filter(sgi_filter),
        .sgi_cpus(sgi_cpus), .dist_enable(dist_enable)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic acc(bit wr, bit wd, logic [11:0] off, logic [31:0] d,
                       logic [31:0] er, bit ef, string tag);
        exp_d_q.push_back(er);
        exp_f_q.push_back(ef);
        exp_t_q.push_back(tag);
        req_valid  = 1'b1;
        req_write  = wr;
        req_word   = wd;
        req_offset = off;
        req_wdata  = d;
        @(negedge clk);
        req_valid  = 1'b0;
    endtask

    task automatic wrw(logic [11:0] off, logic [31:0] d, string tag);
        acc(1'b1, 1'b1, off, d, 32'h0, 1'b0, tag);
    endtask

    task automatic rdw(logic [11:0] off, logic [31:0] e, string tag);
        acc(1'b0, 1'b1, off, 32'h0, e, 1'b0, tag);
    endtask

    // Monitor: compares every response and every pulse against the queues
    always @(negedge clk) begin
        if (!rst) begin
            if (rsp_valid) begin
                if (exp_d_q.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R12: unexpected response actual=%08h expected=none", rsp_rdata);
                end else begin
                    string t;
                    logic [31:0] ed;
                    logic ef;
                    t  = exp_t_q.pop_front();
                    ed = exp_d_q.pop_front();
                    ef = exp_f_q.pop_front();
                    chk({t, " data"}, rsp_rdata, ed);
                    chk({t, " fault"}, {31'h0, rsp_fault}, {31'h0, ef});
                end
            end
            if (sgi_valid) begin
                if (exp_s_q.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R6/R11: stray pulse actual=%h expected=none",
                             {sgi_intid, sgi_filter, sgi_cpus});
                end else begin
                    chk("R6 sgi fields", {18'h0, sgi_intid, sgi_filter, sgi_cpus},
                        {18'h0, exp_s_q.pop_front()});
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12 reset state
        chk("R12 dist_enable after reset", {31'h0, dist_enable}, 32'h0);
        rdw(12'h000, 32'h0, "R12 ctrl reset");
        rdw(12'h104, 32'h0, "R12 enable reset");
        rdw(12'h420, 32'h0, "R12 priority reset");
        rdw(12'hC0C, 32'h0, "R12 config reset");

        // R8 identification and control
        rdw(12'h004, 32'h0000_00E1, "R8 type");
        rdw(12'h008, 32'h0100_0A5C, "R8 iidr");
        rdw(12'hFE8, 32'h0000_0020, "R8 pid2");
        wrw(12'h004, 32'hFFFF_FFFF, "R8 type write");
        wrw(12'h008, 32'h0, "R8 iidr write");
        wrw(12'hFE8, 32'hFFFF_FFFF, "R8 pid2 write");
        rdw(12'h004, 32'h0000_00E1, "R8 type unchanged");
        rdw(12'h008, 32'h0100_0A5C, "R8 iidr unchanged");
        rdw(12'hFE8, 32'h0000_0020, "R8 pid2 unchanged");
        wrw(12'h000, 32'h0000_0001, "R8 ctrl set");
        chk("R8 dist_enable on", {31'h0, dist_enable}, 32'h1);
        rdw(12'h000, 32'h1, "R8 ctrl readback");

        // R2 enable set/clear
        wrw(12'h100, 32'h8000_0011, "R2 set word0");
        wrw(12'h104, 32'h0000_0003, "R2 set word1");
        rdw(12'h100, 32'h8000_0011, "R2 read set word0");
        rdw(12'h184, 32'h0000_0003, "R2 read clear word1");
        wrw(12'h180, 32'h0000_0010, "R2 clear irq4");
        rdw(12'h100, 32'h8000_0001, "R2 after clear");
        wrw(12'h100, 32'h0, "R2 zero set");
        wrw(12'h184, 32'h0, "R2 zero clear");
        rdw(12'h180, 32'h8000_0001, "R2 zeros no effect word0");
        rdw(12'h104, 32'h0000_0003, "R2 zeros no effect word1");

        // R10 beyond NUM_IRQ
        wrw(12'h108, 32'hFFFF_FFFF, "R10 enable word2 write");
        rdw(12'h108, 32'h0, "R10 enable word2 read");

        // R3 priority lanes
        wrw(12'h420, 32'h4433_2211, "R3 prio word write");
        acc(1'b0, 1'b0, 12'h422, 32'h0, 32'h0000_0033, 1'b0, "R3 prio byte read lane2");
        acc(1'b1, 1'b0, 12'h421, 32'h0000_00AB, 32'h0, 1'b0, "R3 prio byte write lane1");
        acc(1'b1, 1'b0, 12'h423, 32'hFFFF_FF5C, 32'h0, 1'b0, "R3 prio byte write junk upper");
        rdw(12'h420, 32'h5C33_AB11, "R3 prio word read order");
        rdw(12'h43C, 32'h0, "R3 prio untouched word");
        wrw(12'h440, 32'hFFFF_FFFF, "R10 prio irq64 write");
        rdw(12'h440, 32'h0, "R10 prio irq64 read");

        // R1 / R11 faults
        acc(1'b0, 1'b1, 12'h421, 32'h0, 32'h0, 1'b1, "R1 unaligned word read prio");
        acc(1'b1, 1'b1, 12'h421, 32'h0, 32'h0, 1'b1, "R11 unaligned word write prio");
        rdw(12'h420, 32'h5C33_AB11, "R11 prio unchanged after fault");
        acc(1'b0, 1'b0, 12'h100, 32'h0, 32'h0, 1'b1, "R1 byte read enable");
        acc(1'b1, 1'b0, 12'h000, 32'h0, 32'h0, 1'b1, "R11 byte write ctrl");
        chk("R11 dist_enable kept", {31'h0, dist_enable}, 32'h1);
        acc(1'b1, 1'b1, 12'h102, 32'hFFFF_FFFF, 32'h0, 1'b1, "R11 unaligned enable write");
        rdw(12'h100, 32'h8000_0001, "R11 enable unchanged");
        acc(1'b1, 1'b0, 12'hF00, 32'h0000_0005, 32'h0, 1'b1, "R11 byte write sgi no pulse");
        acc(1'b0, 1'b0, 12'hF13, 32'h0, 32'h0, 1'b0, "R1 byte sgi pend legal");
        acc(1'b0, 1'b0, 12'h80B, 32'h0, 32'h0000_0001, 1'b0, "R1 byte target legal");

        // R4 targets
        rdw(12'h800, 32'h0101_0101, "R4 private targets");
        wrw(12'h800, 32'hFFFF_FFFF, "R4 private write");
        rdw(12'h800, 32'h0101_0101, "R4 private unchanged");
        wrw(12'h820, 32'h0804_0201, "R4 shared word write");
        acc(1'b1, 1'b0, 12'h822, 32'h0000_0080, 32'h0, 1'b0, "R4 shared byte write");
        rdw(12'h820, 32'h0880_0201, "R4 shared readback");
        rdw(12'h840, 32'h0, "R10 target irq64 read");

        // R5 configuration
        wrw(12'hC00, 32'hFFFF_FFFF, "R5 cfg word0 write");
        wrw(12'hC04, 32'hFFFF_FFFF, "R5 cfg word1 write");
        rdw(12'hC00, 32'h0, "R5 cfg word0 raz");
        rdw(12'hC04, 32'h0, "R5 cfg word1 raz");
        wrw(12'hC08, 32'hA5A5_5A5A, "R5 cfg word2 write");
        wrw(12'hC0C, 32'h0000_000F, "R5 cfg word3 write");
        rdw(12'hC08, 32'hA5A5_5A5A, "R5 cfg word2 read");
        rdw(12'hC0C, 32'h0000_000F, "R5 cfg word3 read");
        wrw(12'hC10, 32'hFFFF_FFFF, "R10 cfg word4 write");
        rdw(12'hC10, 32'h0, "R10 cfg word4 read");

        // R6 software interrupt decode
        exp_s_q.push_back({4'hB, 2'd2, 8'hA5});
        wrw(12'hF00, 32'h02A5_000B, "R6 sgi write A");
        exp_s_q.push_back({4'h7, 2'd1, 8'hC3});
        wrw(12'hF00, 32'hFDC3_FFF7, "R6 sgi write B junk bits");
        rdw(12'hF00, 32'h0, "R7 sgi reads zero");

        // R7 inert regions
        wrw(12'h080, 32'hFFFF_FFFF, "R7 group write");
        rdw(12'h080, 32'h0, "R7 group read");
        wrw(12'h200, 32'hFFFF_FFFF, "R7 pending set write");
        rdw(12'h200, 32'h0, "R7 pending set read");
        wrw(12'h384, 32'hFFFF_FFFF, "R7 active clear write");
        rdw(12'h384, 32'h0, "R7 active clear read");
        acc(1'b1, 1'b0, 12'hF21, 32'h0000_00FF, 32'h0, 1'b0, "R7 sgi pend byte write");
        rdw(12'hF20, 32'h0, "R7 sgi pend read");
        rdw(12'h100, 32'h8000_0001, "R7 enables untouched");

        // R9 reserved
        wrw(12'h010, 32'hFFFF_FFFF, "R9 reserved write");
        rdw(12'h010, 32'h0, "R9 reserved read");
        rdw(12'hD00, 32'h0, "R9 reserved cfg gap");
        rdw(12'hFFC, 32'h0, "R9 reserved top");
        acc(1'b0, 1'b0, 12'hD01, 32'h0, 32'h0, 1'b1, "R1 reserved byte faults");
        rdw(12'h000, 32'h1, "R9 ctrl untouched");

        repeat (3) @(negedge clk);
        chk("R12 all responses seen", exp_d_q.size(), 0);
        chk("R6 all pulses seen", exp_s_q.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule